// File: doc/BRIEF.md
# Paged PHY Status Register Window

This block holds the control and status registers of a serial-bus PHY. Software reaches it through a plain register port with a 4-bit address, 8-bit write data and a combinational read path. The lower eight addresses hold three registers. One holds control bits. One holds sticky status flags, which hardware events set and which software clears by writing one. The third holds a page and port selector. The upper eight addresses form a window whose contents depend on the selected page and, on the per-port page, on the selected port.

Hardware feeds the block per-port line status (connected, bias, disabled, fault, resume) and single-cycle event strobes for loop detection and arbitration timeout. It also feeds the level of the cable power status. Writing the short-reset trigger produces a one-cycle request pulse toward the arbitration logic. Port-change detection compares each status input with its value from the previous cycle. A change raises the port-event flag only for ports whose interrupt enable is set. A rising resume line raises the flag only while the watchdog control bit is set.

Top module: `phy_csr_window`

## Requirements
- R1: Writing address 0 with bit 0 set drives `short_reset_req` high for exactly the one cycle after the write. Bit 0 of address 0 always reads 0.
- R2: Address 1 holds the status flags: bit 0 loop, bit 1 power fail, bit 2 arbitration timeout, bit 3 port event. Writing one to a bit clears it, and writing zero leaves it unchanged.
- R3: A cycle with `loop_evt` high sets the loop flag. A cycle with `arb_timeout_evt` high sets the timeout flag.
- R4: A one-to-zero transition of `cable_pwr` sets the power-fail flag. A zero-to-one transition does not.
- R5: If a hardware set and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R6: A change on any of connected, bias, disabled or fault of port p sets the port-event flag when the interrupt enable of p is 1. The same change leaves the flag clear when that enable is 0.
- R7: A rising edge on `port_resume[p]` of any port sets the port-event flag only while the watchdog bit is 1. A falling edge never sets it.
- R8: Address 0 holds three read/write controls: bit 1 acceleration enable (drives `accel_en`), bit 2 multispeed enable (drives `multi_en`) and bit 3 watchdog. Address 2 holds the page in bits 2:0 and the port in bits 7:4, and reads back as written with bit 3 at 0.
- R9: On page 0 with a valid port, address 8 reads {resume, fault, disabled, bias, connected} of that port in bits 4:0. Address 9 bit 0 is that port's read/write interrupt enable. All other window addresses, all window addresses on pages 1 to 7, and addresses 3 to 7 read zero.
- R10: With a port selection at or above `NPORTS`, every window address reads zero and writes to address 9 change no port's interrupt enable.
- R11: After reset, every field reads zero except acceleration enable, which reads one. `short_reset_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| port_connected | input | NPORTS | Per-port connected status |
| port_bias | input | NPORTS | Per-port bias status |
| port_disabled | input | NPORTS | Per-port disabled status |
| port_fault | input | NPORTS | Per-port fault status |
| port_resume | input | NPORTS | Per-port resume activity |
| loop_evt | input | 1 | Loop detected strobe |
| arb_timeout_evt | input | 1 | Arbitration timeout strobe |
| cable_pwr | input | 1 | Cable power present level |
| short_reset_req | output | 1 | One-cycle arbitrated short bus reset request |
| accel_en | output | 1 | Acceleration enable control |
| multi_en | output | 1 | Multispeed concatenation enable control |

## Verification
The assertions assume that event strobes and status lines change only between clock edges. They also assume the power level is stable during reset, because the previous-value registers follow their inputs while reset is held. The bench drives every input on the falling edge and holds `cable_pwr` high through reset. It keeps the port status lines at zero until reset is released, so no change appears in the first cycle. The sweeps cover every port, every status line, both enable values, both watchdog values and all sixteen port selections. Expected flag values come from the bench's own copies of the enables and line values.

// File: rtl/phy_csr_window.sv
module phy_csr_window #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NPORTS-1:0] port_connected,
  input  logic [NPORTS-1:0] port_bias,
  input  logic [NPORTS-1:0] port_disabled,
  input  logic [NPORTS-1:0] port_fault,
  input  logic [NPORTS-1:0] port_resume,
  input  logic              loop_evt,
  input  logic              arb_timeout_evt,
  input  logic              cable_pwr,
  output logic              short_reset_req,
  output logic              accel_en,
  output logic              multi_en
);
  logic              accel_q, multi_q, wdog_q, req_q;
  logic              loop_q, pwrf_q, arbto_q, pevt_q;
  logic [2:0]        page_q;
  logic [3:0]        port_q;
  logic [NPORTS-1:0] int_en_q;
  logic [NPORTS-1:0] conn_d, bias_d, dis_d, fault_d, res_d;
  logic              pwr_d;

  logic wr_ctl, wr_sts, wr_sel, wr_ie, port_ok, chg_any, res_any;
  logic pwr_fall, pevt_set;
  logic [4:0] sel_stat;
  logic       sel_ie;

  assign wr_ctl   = wr_en && addr == 4'd0;
  assign wr_sts   = wr_en && addr == 4'd1;
  assign wr_sel   = wr_en && addr == 4'd2;
  assign port_ok  = 32'(port_q) < NPORTS;
  assign wr_ie    = wr_en && addr == 4'd9 && page_q == 3'd0 && port_ok;
  assign chg_any  = |(((port_connected ^ conn_d) | (port_bias ^ bias_d) |
                       (port_disabled ^ dis_d) | (port_fault ^ fault_d)) & int_en_q);
  assign res_any  = |(port_resume & ~res_d);
  assign pevt_set = chg_any || (wdog_q && res_any);
  assign pwr_fall = pwr_d && !cable_pwr;

  assign short_reset_req = req_q;
  assign accel_en        = accel_q;
  assign multi_en        = multi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accel_q <= 1'b1;
      multi_q <= 1'b0;
      wdog_q  <= 1'b0;
      req_q   <= 1'b0;
      loop_q  <= 1'b0;
      pwrf_q  <= 1'b0;
      arbto_q <= 1'b0;
      pevt_q  <= 1'b0;
      page_q  <= '0;
      port_q  <= '0;
    end else begin
      req_q <= wr_ctl && wdata[0];
      if (wr_ctl) begin
        accel_q <= wdata[1];
        multi_q <= wdata[2];
        wdog_q  <= wdata[3];
      end
      if (wr_sel) begin
        page_q <= wdata[2:0];
        port_q <= wdata[7:4];
      end
      loop_q  <= (loop_q  & ~(wr_sts & wdata[0])) | loop_evt;
      pwrf_q  <= (pwrf_q  & ~(wr_sts & wdata[1])) | pwr_fall;
      arbto_q <= (arbto_q & ~(wr_sts & wdata[2])) | arb_timeout_evt;
      pevt_q  <= (pevt_q  & ~(wr_sts & wdata[3])) | pevt_set;
    end
  end

  always_ff @(posedge clk) begin
    conn_d  <= port_connected;
    bias_d  <= port_bias;
    dis_d   <= port_disabled;
    fault_d <= port_fault;
    res_d   <= port_resume;
    pwr_d   <= cable_pwr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) int_en_q <= '0;
    else
      for (int i = 0; i < NPORTS; i++)
        if (wr_ie && port_q == 4'(i)) int_en_q[i] <= wdata[0];
  end

  always_comb begin
    sel_stat = '0;
    sel_ie   = 1'b0;
    for (int i = 0; i < NPORTS; i++)
      if (port_q == 4'(i)) begin
        sel_stat = {port_resume[i], port_fault[i], port_disabled[i],
                    port_bias[i], port_connected[i]};
        sel_ie   = int_en_q[i];
      end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      4'd0: rdata = {4'b0, wdog_q, multi_q, accel_q, 1'b0};
      4'd1: rdata = {4'b0, pevt_q, arbto_q, pwrf_q, loop_q};
      4'd2: rdata = {port_q, 1'b0, page_q};
      4'd8: if (page_q == 3'd0) rdata = {3'b0, sel_stat};
      4'd9: if (page_q == 3'd0) rdata = {7'b0, sel_ie};
      default: rdata = '0;
    endcase
  end
endmodule

module phy_csr_window_chk #(
  parameter int NPORTS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       short_reset_req,
  input logic       loop_evt,
  input logic       loop_st,
  input logic       cable_pwr,
  input logic       pwrf_st,
  input logic [3:0] port_sel
);
  assert_req_from_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    short_reset_req |-> $past(wr_en && addr == 4'd0 && wdata[0]));
  assert_trigger_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 4'd0 |-> !rdata[0]);
  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd1 && wdata[0] && !loop_evt) |=> !loop_st);
  assert_loop_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_evt |=> loop_st);
  assert_pwr_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cable_pwr) |=> pwrf_st);
  assert_blank_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[3] && 32'(port_sel) >= NPORTS) |-> rdata == 8'h00);
endmodule

bind phy_csr_window phy_csr_window_chk #(.NPORTS(NPORTS)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .short_reset_req(short_reset_req), .loop_evt(loop_evt),
  .loop_st(loop_q), .cable_pwr(cable_pwr), .pwrf_st(pwrf_q), .port_sel(port_q)
);

// File: tb/phy_csr_window_test.sv
`timescale 1ns/1ps
module phy_csr_window_test;
  localparam int NP = 4;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NP-1:0] conn = 0, bias = 0, dis = 0, fault = 0, res = 0;
  logic loop_evt = 0, arb_evt = 0, pwr = 1;
  logic req, accel, multi;
  int checks = 0, fails = 0;
  logic [NP-1:0] ie = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phy_csr_window #(.NPORTS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .port_connected(conn), .port_bias(bias),
    .port_disabled(dis), .port_fault(fault), .port_resume(res),
    .loop_evt(loop_evt), .arb_timeout_evt(arb_evt), .cable_pwr(pwr),
    .short_reset_req(req), .accel_en(accel), .multi_en(multi));

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rdchk(string tag, logic [3:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  function automatic logic [7:0] stat(int p);
    return {3'b0, res[p], fault[p], dis[p], bias[p], conn[p]};
  endfunction

  task automatic flip(int p, int f);
    @(negedge clk);
    case (f)
      0: conn[p] = ~conn[p];
      1: bias[p] = ~bias[p];
      2: dis[p] = ~dis[p];
      default: fault[p] = ~fault[p];
    endcase
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rdchk("R11 ctl", 4'd0, 8'h02);
    rdchk("R11 sts", 4'd1, 8'h00);
    rdchk("R11 sel", 4'd2, 8'h00);
    chk("R11 outs", {5'b0, req, accel, multi}, 8'h02);
    // R8 controls and selector
    wr(4'd0, 8'h0C);
    rdchk("R8 ctl", 4'd0, 8'h0C);
    chk("R8 outs", {6'b0, accel, multi}, 8'h01);
    wr(4'd0, 8'h02);
    chk("R8 outs2", {6'b0, accel, multi}, 8'h02);
    wr(4'd2, 8'hFF);
    rdchk("R8 sel", 4'd2, 8'hF7);
    wr(4'd2, 8'h00);
    // R1 short reset trigger
    wr(4'd0, 8'h03);
    chk("R1 pulse", {7'b0, req}, 8'h01);
    rdchk("R1 readback", 4'd0, 8'h02);
    tick();
    chk("R1 one cycle", {7'b0, req}, 8'h00);
    // R3 R4 R2
    @(negedge clk); loop_evt = 1; @(negedge clk); loop_evt = 0;
    rdchk("R3 loop", 4'd1, 8'h01);
    @(negedge clk); arb_evt = 1; @(negedge clk); arb_evt = 0;
    rdchk("R3 arb", 4'd1, 8'h05);
    @(negedge clk); pwr = 0; @(negedge clk);
    rdchk("R4 fall", 4'd1, 8'h07);
    wr(4'd1, 8'h02);
    @(negedge clk); pwr = 1; @(negedge clk);
    rdchk("R4 rise", 4'd1, 8'h05);
    wr(4'd1, 8'h00);
    rdchk("R2 write zero", 4'd1, 8'h05);
    wr(4'd1, 8'h01);
    rdchk("R2 clear one", 4'd1, 8'h04);
    wr(4'd1, 8'h0F);
    rdchk("R2 clear all", 4'd1, 8'h00);
    // R5 set wins
    @(negedge clk); wr_en = 1; addr = 4'd1; wdata = 8'h05; loop_evt = 1; arb_evt = 1;
    @(negedge clk); wr_en = 0; loop_evt = 0; arb_evt = 0;
    rdchk("R5 set wins", 4'd1, 8'h05);
    wr(4'd1, 8'h0F);
    // R6 port change sweep
    for (int p = 0; p < NP; p++)
      for (int en = 0; en < 2; en++) begin
        wr(4'd2, 8'(p << 4));
        wr(4'd9, 8'(en));
        ie[p] = en[0];
        rdchk("R9 int enable", 4'd9, 8'(en));
        for (int f = 0; f < 4; f++)
          for (int k = 0; k < 2; k++) begin
            flip(p, f);
            rdchk("R6 port event", 4'd1, en[0] ? 8'h08 : 8'h00);
            rdchk("R9 port status", 4'd8, stat(p));
            wr(4'd1, 8'h08);
          end
      end
    // R7 resume with watchdog
    for (int w = 0; w < 2; w++) begin
      wr(4'd0, w[0] ? 8'h0A : 8'h02);
      for (int p = 0; p < NP; p++) begin
        wr(4'd2, 8'(p << 4));
        @(negedge clk); res[p] = 1; @(negedge clk);
        rdchk("R7 resume rise", 4'd1, w[0] ? 8'h08 : 8'h00);
        rdchk("R9 resume status", 4'd8, stat(p));
        wr(4'd1, 8'h08);
        @(negedge clk); res[p] = 0; @(negedge clk);
        rdchk("R7 resume fall", 4'd1, 8'h00);
      end
    end
    wr(4'd0, 8'h02);
    // R9 pages and unmapped addresses
    ie = '0;
    for (int p = 0; p < NP; p++) begin
      wr(4'd2, 8'(p << 4)); wr(4'd9, 8'h00);
    end
    @(negedge clk); conn = '1; bias = '1; @(negedge clk);
    for (int pg = 1; pg < 8; pg++) begin
      wr(4'd2, 8'(pg));
      for (int a = 8; a < 16; a++) rdchk("R9 other page", 4'(a), 8'h00);
    end
    wr(4'd2, 8'h00);
    rdchk("R9 page0", 4'd8, 8'h03);
    for (int a = 10; a < 16; a++) rdchk("R9 page0 unused", 4'(a), 8'h00);
    for (int a = 3; a < 8; a++) rdchk("R9 unmapped", 4'(a), 8'h00);
    // R10 invalid port selections
    for (int p = NP; p < 16; p++) begin
      wr(4'd2, 8'(p << 4));
      wr(4'd9, 8'h01);
      for (int a = 8; a < 16; a++) rdchk("R10 blank window", 4'(a), 8'h00);
    end
    for (int p = 0; p < NP; p++) begin
      wr(4'd2, 8'(p << 4));
      rdchk("R10 enable untouched", 4'd9, 8'h00);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule